// File: doc/BRIEF.md
# Grouped Rail Power Sequencer

This block drives the enable pins of a set of power rails divided into three ordered groups. When the power request rises, it turns the groups on one after another. A group is only enabled once every rail of the group before it reports that it has passed ninety percent of its nominal level. When the request falls, it turns the groups off in the opposite order. A group is only disabled once every rail of the group above it reports that it has dropped under ten percent of nominal. The comparator flags come from external supervisors. The block only consumes them.

A fault flag on any enabled rail starts an orderly shutdown from the highest group that is enabled. The block then stores the failing rail and the state it was in. A wait that runs past a timeout is handled as a fault of the rail that is still missing its flag. After a fault shutdown the block waits a fixed delay and then starts again. It does this a limited number of times. After the last allowed retry it stays off until the request is removed. A system-ready output is high only while all three groups are up.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, all enables are low, ready is low, the state code is 0 (off) and the fault record is not valid.
- R2: Rails `g*RAILS_PER_GRP` to `g*RAILS_PER_GRP+RAILS_PER_GRP-1` form group g, where group 0 powers up first. When the request is raised in state 0, the next cycle shows state 1 with only group 0 enabled. Each later cycle in which the waited-on group is fully above threshold advances the state one step: state 2 enables groups 0 and 1, state 3 enables all groups, and state 4 means on.
- R3: The block stays in an up state with no extra group enabled while any rail of the group it waits on lacks its above-threshold flag.
- R4: Ready is high only in state 4, and all enables are high whenever ready is high. When the request drops in state 4, the next cycle shows state 5 with ready low and every enable still high.
- R5: From state 5 the block moves to state 6 with group 2 disabled. It moves to state 7 (group 1 disabled) and then to state 8 (group 0 disabled), each only after every rail of the group just disabled shows its below-threshold flag. After that it returns to state 0.
- R6: A fault flag on an enabled rail in states 1 to 4 sets the fault record. The record holds the lowest faulting rail index, the state code at the time of the fault, and a timeout bit of 0. The block then shuts down: from state 4 through state 5, and from state k in 1 to 3 straight to the down state that disables group k-1. Fault flags on disabled rails are ignored.
- R7: A fault and the completion of the waited-on group in the same cycle are handled as a fault.
- R8: A wait of TIMEOUT_CYC cycles in an up state without completion is recorded as a fault with the timeout bit set. The recorded rail is the lowest rail of that group without its flag.
- R9: After a fault shutdown disables group 0, the block stays in state 9 for RETRY_DLY_CYC cycles and then re-enters state 1 while keeping the fault record.
- R10: After MAX_RETRY automatic restarts, the next fault shutdown ends in state 10 with all enables low. The block stays there until the request is low, then goes to state 0. A new request from state 0 clears the record and the retry count.
- R11: Dropping the request during an up state starts the down sequence from the highest enabled group without setting a fault.
- R12: A down state that waits TIMEOUT_CYC cycles records a timeout fault for the lowest rail still above its low threshold, then advances anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Power-on request |
| rail_hi | input | 3*RAILS_PER_GRP | Per-rail flag: above 90% of nominal |
| rail_lo | input | 3*RAILS_PER_GRP | Per-rail flag: below 10% of nominal |
| rail_flt | input | 3*RAILS_PER_GRP | Per-rail fault flag |
| rail_en | output | 3*RAILS_PER_GRP | Per-rail enable |
| sys_ready | output | 1 | All groups up |
| seq_state | output | 4 | Sequencer state code |
| flt_valid | output | 1 | Fault record holds a fault |
| flt_rail | output | $clog2(3*RAILS_PER_GRP) | Index of the failing rail |
| flt_state | output | 4 | State code when the fault was taken |
| flt_timeout | output | 1 | Recorded fault was a wait timeout |

## Verification
The main collision is a fault flag and the completion of a group arriving in the same cycle. To provoke it, the bench holds the middle group below threshold, then releases it on the same clock in which a group-0 rail reports a fault. The pass condition is that the next state is the group-1 down state, not the next up state, and that the record names the faulting rail and state 2. A second collision, a timeout against a late flag, is checked by measuring the exact number of cycles spent in the waiting state before the timeout record appears.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam int NGRP = 3;

    typedef enum logic [3:0] {
        ST_OFF  = 4'd0,
        ST_UP1  = 4'd1,
        ST_UP2  = 4'd2,
        ST_UP3  = 4'd3,
        ST_ON   = 4'd4,
        ST_STOP = 4'd5,
        ST_DN3  = 4'd6,
        ST_DN2  = 4'd7,
        ST_DN1  = 4'd8,
        ST_WAIT = 4'd9,
        ST_LOCK = 4'd10
    } seq_state_e;
endpackage

// File: rtl/rseq_grp_eval.sv
module rseq_grp_eval #(
    parameter int RPG = 2,
    localparam int LW = (RPG > 1) ? $clog2(RPG) : 1
) (
    input  logic [RPG-1:0] hi,
    input  logic [RPG-1:0] lo,
    input  logic [RPG-1:0] flt,
    input  logic [RPG-1:0] en,
    output logic           all_hi,
    output logic           all_lo,
    output logic           flt_any,
    output logic [LW-1:0]  flt_loc,
    output logic [LW-1:0]  miss_hi_loc,
    output logic [LW-1:0]  miss_lo_loc
);
    logic [RPG-1:0] live_flt;

    always_comb begin
        live_flt    = flt & en;
        all_hi      = &hi;
        all_lo      = &lo;
        flt_any     = |live_flt;
        flt_loc     = '0;
        miss_hi_loc = '0;
        miss_lo_loc = '0;
        // descending scan leaves the lowest matching index
        for (int i = RPG - 1; i >= 0; i--) begin
            if (live_flt[i]) flt_loc     = LW'(i);
            if (!hi[i])      miss_hi_loc = LW'(i);
            if (!lo[i])      miss_lo_loc = LW'(i);
        end
    end
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !run)
            cnt_d = '0;
        else if (cnt_q != CW'(LIMIT - 1))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // R8: the wait counter never runs past its limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rseq_pkg::*;
#(
    parameter int RAILS_PER_GRP = 2,
    parameter int TIMEOUT_CYC   = 1000,
    parameter int RETRY_DLY_CYC = 5000,
    parameter int MAX_RETRY     = 3,
    localparam int NR = NGRP * RAILS_PER_GRP,
    localparam int IW = $clog2(NR),
    localparam int LW = (RAILS_PER_GRP > 1) ? $clog2(RAILS_PER_GRP) : 1,
    localparam int CW = $clog2(MAX_RETRY + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_req,
    input  logic [NR-1:0] rail_hi,
    input  logic [NR-1:0] rail_lo,
    input  logic [NR-1:0] rail_flt,
    output logic [NR-1:0] rail_en,
    output logic          sys_ready,
    output logic [3:0]    seq_state,
    output logic          flt_valid,
    output logic [IW-1:0] flt_rail,
    output logic [3:0]    flt_state,
    output logic          flt_timeout
);
    localparam int RPG = RAILS_PER_GRP;

    typedef struct packed {
        seq_state_e    st;
        logic [NR-1:0] en;
        logic          rdy;
        logic          fv;
        logic [IW-1:0] frail;
        logic [3:0]    fst;
        logic          ftmo;
        logic          pend;
        logic [CW-1:0] rcnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [NGRP-1:0] all_hi, all_lo, flt_any;
    logic [IW-1:0]   flt_glb [NGRP];
    logic [IW-1:0]   mhi_glb [NGRP];
    logic [IW-1:0]   mlo_glb [NGRP];
    logic [IW-1:0]   fsel;
    logic            any_flt;
    logic [1:0]      wg;
    logic            pend_now;
    logic            tmo_exp, dly_exp, tmo_run, tmo_clr, dly_run;

    // ---------------- per-group evaluation ----------------
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [LW-1:0] fl, mh, ml;
        rseq_grp_eval #(.RPG(RPG)) i_eval (
            .hi          (rail_hi[g*RPG +: RPG]),
            .lo          (rail_lo[g*RPG +: RPG]),
            .flt         (rail_flt[g*RPG +: RPG]),
            .en          (r_q.en[g*RPG +: RPG]),
            .all_hi      (all_hi[g]),
            .all_lo      (all_lo[g]),
            .flt_any     (flt_any[g]),
            .flt_loc     (fl),
            .miss_hi_loc (mh),
            .miss_lo_loc (ml)
        );
        assign flt_glb[g] = IW'(g * RPG) + IW'(fl);
        assign mhi_glb[g] = IW'(g * RPG) + IW'(mh);
        assign mlo_glb[g] = IW'(g * RPG) + IW'(ml);
    end

    always_comb begin
        fsel = '0;
        for (int g = NGRP - 1; g >= 0; g--)
            if (flt_any[g]) fsel = flt_glb[g];
    end
    assign any_flt = |flt_any;

    // ---------------- timers ----------------
    assign tmo_run = (r_q.st inside {ST_UP1, ST_UP2, ST_UP3, ST_DN3, ST_DN2, ST_DN1});
    assign tmo_clr = (r_d.st != r_q.st);
    assign dly_run = (r_q.st == ST_WAIT);

    rseq_timer #(.LIMIT(TIMEOUT_CYC)) i_tmo (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(tmo_run), .expired(tmo_exp));

    rseq_timer #(.LIMIT(RETRY_DLY_CYC)) i_dly (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(dly_run), .expired(dly_exp));

    // ---------------- helpers ----------------
    function automatic logic [1:0] wait_grp(seq_state_e s);
        case (s)
            ST_UP2, ST_DN2: return 2'd1;
            ST_UP3, ST_DN3: return 2'd2;
            default:        return 2'd0;
        endcase
    endfunction

    function automatic seq_state_e down_of(logic [1:0] g);
        case (g)
            2'd2:    return ST_DN3;
            2'd1:    return ST_DN2;
            default: return ST_DN1;
        endcase
    endfunction

    function automatic int grp_on(seq_state_e s);
        case (s)
            ST_UP1, ST_DN2:               return 1;
            ST_UP2, ST_DN3:               return 2;
            ST_UP3, ST_ON, ST_STOP:       return 3;
            default:                      return 0;
        endcase
    endfunction

    // ---------------- next-state logic ----------------
    always_comb begin
        r_d      = r_q;
        wg       = wait_grp(r_q.st);
        pend_now = r_q.pend;
        case (r_q.st)
            ST_OFF: begin
                if (pwr_req) begin
                    r_d.st    = ST_UP1;
                    r_d.fv    = 1'b0;
                    r_d.frail = '0;
                    r_d.fst   = '0;
                    r_d.ftmo  = 1'b0;
                    r_d.pend  = 1'b0;
                    r_d.rcnt  = '0;
                end
            end
            ST_UP1, ST_UP2, ST_UP3: begin
                if (any_flt) begin
                    r_d.fv    = 1'b1;
                    r_d.frail = fsel;
                    r_d.fst   = r_q.st;
                    r_d.ftmo  = 1'b0;
                    r_d.pend  = 1'b1;
                    r_d.st    = down_of(wg);
                end else if (!pwr_req) begin
                    r_d.st = down_of(wg);
                end else if (all_hi[wg]) begin
                    r_d.st = (r_q.st == ST_UP1) ? ST_UP2 :
                             (r_q.st == ST_UP2) ? ST_UP3 : ST_ON;
                end else if (tmo_exp) begin
                    r_d.fv    = 1'b1;
                    r_d.frail = mhi_glb[wg];
                    r_d.fst   = r_q.st;
                    r_d.ftmo  = 1'b1;
                    r_d.pend  = 1'b1;
                    r_d.st    = down_of(wg);
                end
            end
            ST_ON: begin
                if (any_flt) begin
                    r_d.fv    = 1'b1;
                    r_d.frail = fsel;
                    r_d.fst   = r_q.st;
                    r_d.ftmo  = 1'b0;
                    r_d.pend  = 1'b1;
                    r_d.st    = ST_STOP;
                end else if (!pwr_req) begin
                    r_d.st = ST_STOP;
                end
            end
            ST_STOP: r_d.st = ST_DN3;
            ST_DN3, ST_DN2, ST_DN1: begin
                if (tmo_exp && !all_lo[wg] && !r_q.pend) begin
                    r_d.fv    = 1'b1;
                    r_d.frail = mlo_glb[wg];
                    r_d.fst   = r_q.st;
                    r_d.ftmo  = 1'b1;
                    r_d.pend  = 1'b1;
                    pend_now  = 1'b1;
                end
                if (all_lo[wg] || tmo_exp) begin
                    case (r_q.st)
                        ST_DN3:  r_d.st = ST_DN2;
                        ST_DN2:  r_d.st = ST_DN1;
                        default: r_d.st = !pend_now ? ST_OFF :
                                          (r_q.rcnt < CW'(MAX_RETRY)) ? ST_WAIT : ST_LOCK;
                    endcase
                end
            end
            ST_WAIT: begin
                if (!pwr_req) begin
                    r_d.st = ST_OFF;
                end else if (dly_exp) begin
                    r_d.rcnt = r_q.rcnt + 1'b1;
                    r_d.pend = 1'b0;
                    r_d.st   = ST_UP1;
                end
            end
            ST_LOCK: if (!pwr_req) r_d.st = ST_OFF;
            default: r_d.st = ST_OFF;
        endcase

        for (int r = 0; r < NR; r++)
            r_d.en[r] = ((r / RPG) < grp_on(r_d.st));
        r_d.rdy = (r_d.st == ST_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rail_en     = r_q.en;
    assign sys_ready   = r_q.rdy;
    assign seq_state   = r_q.st;
    assign flt_valid   = r_q.fv;
    assign flt_rail    = r_q.frail;
    assign flt_state   = r_q.fst;
    assign flt_timeout = r_q.ftmo;

    // ---------------- assertions ----------------
    p_ready_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ready |-> (&rail_en));

    p_ready_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ready |=> (&rail_en[NR-1 -: RPG]));

    for (genvar g = 1; g < NGRP; g++) begin : g_chk
        p_grp_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (|rail_en[g*RPG +: RPG]) |-> (&rail_en[(g-1)*RPG +: RPG]));

        p_up_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[g*RPG]) |-> $past(all_hi[g-1]));

        p_dn_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(rail_en[(g-1)*RPG]) && $past(r_q.st inside {ST_DN3, ST_DN2, ST_DN1}))
            |-> $past(all_lo[g] || tmo_exp));
    end

    p_fault_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_flt && (r_q.st inside {ST_UP1, ST_UP2, ST_UP3, ST_ON})) |=> flt_valid);

    p_lock_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOCK) |-> (rail_en == '0));

    p_retry_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rcnt <= CW'(MAX_RETRY));
endmodule

// File: tb/test_rail_seq_top.sv
module test_rail_seq_top;
    localparam int RPG  = 2;
    localparam int NR   = 3 * RPG;
    localparam int TMO  = 20;
    localparam int RDLY = 10;
    localparam int MAXR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_req = 1'b0;
    logic [NR-1:0] rail_hi, rail_lo;
    logic [NR-1:0] rail_flt = '0;
    logic [NR-1:0] stuck_off = '0;
    logic [NR-1:0] stuck_on  = '0;
    logic [NR-1:0] rail_en;
    logic          sys_ready;
    logic [3:0]    seq_state;
    logic          flt_valid;
    logic [2:0]    flt_rail;
    logic [3:0]    flt_state;
    logic          flt_timeout;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // simple rail model: flags follow enables unless a rail is held
    always_comb begin
        rail_hi = rail_en & ~stuck_off;
        rail_lo = ~rail_en & ~stuck_on;
    end

    rail_seq_top #(
        .RAILS_PER_GRP(RPG), .TIMEOUT_CYC(TMO),
        .RETRY_DLY_CYC(RDLY), .MAX_RETRY(MAXR)
    ) i_rail_seq_top (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
        .rail_hi(rail_hi), .rail_lo(rail_lo), .rail_flt(rail_flt),
        .rail_en(rail_en), .sys_ready(sys_ready), .seq_state(seq_state),
        .flt_valid(flt_valid), .flt_rail(flt_rail), .flt_state(flt_state),
        .flt_timeout(flt_timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_st(input int tgt, input int maxc);
        for (int i = 0; i < maxc && int'(seq_state) != tgt; i++) step();
    endtask

    task automatic go_off();
        pwr_req   = 1'b0;
        rail_flt  = '0;
        stuck_off = '0;
        stuck_on  = '0;
        wait_st(0, 200);
        chk("R5 back to off", int'(seq_state), 0);
    endtask

    task automatic t_reset();
        chk("R1 enables", int'(rail_en), 0);
        chk("R1 ready", int'(sys_ready), 0);
        chk("R1 state", int'(seq_state), 0);
        chk("R1 record", int'(flt_valid), 0);
    endtask

    task automatic t_up_down();
        pwr_req = 1'b1;
        step(); chk("R2 state1", int'(seq_state), 1); chk("R2 en1", int'(rail_en), 'b000011);
        step(); chk("R2 state2", int'(seq_state), 2); chk("R2 en2", int'(rail_en), 'b001111);
        step(); chk("R2 state3", int'(seq_state), 3); chk("R2 en3", int'(rail_en), 'b111111);
        chk("R4 no ready yet", int'(sys_ready), 0);
        step(); chk("R2 on", int'(seq_state), 4); chk("R4 ready", int'(sys_ready), 1);
        pwr_req = 1'b0;
        step(); chk("R4 stop", int'(seq_state), 5); chk("R4 ready low", int'(sys_ready), 0);
        chk("R4 en held", int'(rail_en), 'b111111);
        step(); chk("R5 dn3", int'(seq_state), 6); chk("R5 en dn3", int'(rail_en), 'b001111);
        step(); chk("R5 dn2", int'(seq_state), 7); chk("R5 en dn2", int'(rail_en), 'b000011);
        step(); chk("R5 dn1", int'(seq_state), 8); chk("R5 en dn1", int'(rail_en), 0);
        step(); chk("R5 off", int'(seq_state), 0);
    endtask

    task automatic t_gate();
        stuck_off = 'b000010;
        pwr_req = 1'b1;
        step(5);
        chk("R3 holds state1", int'(seq_state), 1);
        chk("R3 only group0", int'(rail_en), 'b000011);
        stuck_off = '0;
        step();
        chk("R3 advances", int'(seq_state), 2);
        go_off();
    endtask

    task automatic t_ignore();
        stuck_off = 'b000001;
        pwr_req = 1'b1;
        step();
        rail_flt = 'b100000;
        step(3);
        chk("R6 disabled fault ignored state", int'(seq_state), 1);
        chk("R6 disabled fault ignored rec", int'(flt_valid), 0);
        go_off();
    endtask

    task automatic t_fault_on();
        pwr_req = 1'b1;
        step(4);
        rail_flt = 'b001000;
        step();
        rail_flt = '0;
        chk("R6 stop", int'(seq_state), 5);
        chk("R6 ready low", int'(sys_ready), 0);
        chk("R6 valid", int'(flt_valid), 1);
        chk("R6 rail", int'(flt_rail), 3);
        chk("R6 state", int'(flt_state), 4);
        chk("R6 tmo", int'(flt_timeout), 0);
        step();
        chk("R6 orderly dn3", int'(seq_state), 6);
        go_off();
    endtask

    task automatic t_same();
        stuck_off = 'b001100;
        pwr_req = 1'b1;
        step(2);
        chk("R7 waiting", int'(seq_state), 2);
        rail_flt  = 'b000001;
        stuck_off = '0;
        step();
        rail_flt = '0;
        chk("R7 fault wins", int'(seq_state), 7);
        chk("R7 en", int'(rail_en), 'b000011);
        chk("R7 rail", int'(flt_rail), 0);
        chk("R7 state", int'(flt_state), 2);
        go_off();
    endtask

    task automatic t_tmo_up();
        int n = 0;
        stuck_off = 'b000100;
        pwr_req = 1'b1;
        step(2);
        while (int'(seq_state) == 2 && n < 100) begin step(); n++; end
        chk("R8 cycles", n, TMO);
        chk("R8 state", int'(seq_state), 7);
        chk("R8 rail", int'(flt_rail), 2);
        chk("R8 rec state", int'(flt_state), 2);
        chk("R8 tmo bit", int'(flt_timeout), 1);
        go_off();
    endtask

    task automatic t_retry();
        pwr_req = 1'b1;
        step(4);
        rail_flt = 'b000001;
        step();
        rail_flt = '0;
        step(4);
        chk("R9 wait", int'(seq_state), 9);
        chk("R9 en off", int'(rail_en), 0);
        step(RDLY - 1);
        chk("R9 still wait", int'(seq_state), 9);
        step();
        chk("R9 restart", int'(seq_state), 1);
        chk("R9 record kept", int'(flt_valid), 1);
        go_off();
    endtask

    task automatic t_lock();
        int starts = 0;
        int prev = 0;
        rail_flt = 'b000001;
        pwr_req = 1'b1;
        for (int i = 0; i < 500 && int'(seq_state) != 10; i++) begin
            step();
            if (int'(seq_state) == 1 && prev != 1) starts++;
            prev = int'(seq_state);
        end
        chk("R10 lock", int'(seq_state), 10);
        chk("R10 starts", starts, MAXR + 1);
        chk("R10 en off", int'(rail_en), 0);
        step(5);
        chk("R10 held", int'(seq_state), 10);
        pwr_req = 1'b0;
        step();
        chk("R10 release", int'(seq_state), 0);
        rail_flt = '0;
        pwr_req = 1'b1;
        step();
        chk("R10 record cleared", int'(flt_valid), 0);
        go_off();
    endtask

    task automatic t_drop();
        stuck_off = 'b010000;
        pwr_req = 1'b1;
        step(3);
        chk("R11 up3", int'(seq_state), 3);
        pwr_req = 1'b0;
        step();
        chk("R11 dn3", int'(seq_state), 6);
        chk("R11 en", int'(rail_en), 'b001111);
        chk("R11 no fault", int'(flt_valid), 0);
        go_off();
    endtask

    task automatic t_tmo_dn();
        int n = 0;
        pwr_req = 1'b1;
        step(4);
        stuck_on = 'b100000;
        pwr_req = 1'b0;
        step(2);
        while (int'(seq_state) == 6 && n < 100) begin step(); n++; end
        chk("R12 cycles", n, TMO);
        chk("R12 advanced", int'(seq_state), 7);
        chk("R12 rail", int'(flt_rail), 5);
        chk("R12 rec state", int'(flt_state), 6);
        chk("R12 tmo bit", int'(flt_timeout), 1);
        go_off();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_up_down();
        t_gate();
        t_ignore();
        t_fault_on();
        t_same();
        t_tmo_up();
        t_retry();
        t_lock();
        t_drop();
        t_tmo_dn();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule